// File: doc/BRIEF.md
# Byte-Lane Split Bus Sequencer

This block turns requests from a simple internal load/store port into cycles on a 16-bit external data bus with a 20-bit byte address. A request is a read or a write of one byte or one 16-bit word, at any byte address. The block drives the bus address and an active-low high-lane enable. It places write data on the correct byte lanes and gathers read bytes into a right-justified result.

The external bus carries even-addressed bytes on bits 7:0 and odd-addressed bytes on bits 15:8. A word at an even address moves in one bus cycle. A word at an odd address is split into two byte cycles. The first cycle moves the word's low byte at the odd address, on the high lane. The second cycle moves the high byte at the next address, on the low lane. The two halves are rejoined so that the lower address holds the least significant byte.

Each bus cycle holds its strobe high until the external side answers with ready. One pulse on `done` closes every request.

Top module: `lane_seq`

## Requirements
- R1: After reset, `req_ready` is 1, and both `bus_strobe` and `done` are 0.
- R2: A byte access at an even address makes one bus cycle. That cycle drives `bus_bhe_n`=1 with `bus_addr[0]`=0, and uses lane 7:0. On a write, lane 15:8 is driven to zero. On a read, the result is zero-extended.
- R3: A byte access at an odd address makes one bus cycle. That cycle drives `bus_bhe_n`=0 with `bus_addr[0]`=1, and uses lane 15:8. On a write, lane 7:0 is driven to zero. On a read, the result is zero-extended.
- R4: A word access at an even address makes one bus cycle with `bus_bhe_n`=0. Data bits 7:0 belong to the addressed byte and bits 15:8 to the byte at the next address.
- R5: A word access at an odd address A makes two bus cycles. The first uses address A, `bus_bhe_n`=0 and data bits 15:8 for the word's low byte. The second uses address A+1, `bus_bhe_n`=1 and data bits 7:0 for the word's high byte. A read returns {byte at A+1, byte at A}.
- R6: The second cycle of a split word at address 0xFFFFF uses address 0x00000.
- R7: `done` is high for exactly one cycle, the cycle after the clock edge that sees `bus_ready` in the request's last bus cycle. `rdata` is valid for reads in that cycle, and `req_ready` is high again in that same cycle. `req_ready` stays low from acceptance until then.
- R8: While `bus_strobe` is high and `bus_ready` is low, the bus outputs hold steady until the next edge.
- R9: While `bus_strobe` is high, the combination `bus_bhe_n`=1 with `bus_addr[0]`=1 is never driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 16 | Write data, right-justified |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read result, right-justified |
| bus_strobe | output | 1 | Bus cycle in progress |
| bus_we | output | 1 | Bus cycle is a write |
| bus_addr | output | 20 | Bus byte address; bit 0 selects the low lane |
| bus_bhe_n | output | 1 | Active-low high-lane enable |
| bus_wdata | output | 16 | Bus write data |
| bus_rdata | input | 16 | Bus read data |
| bus_ready | input | 1 | Bus cycle completes at this edge |

## Verification
Every address parity is tried with both sizes. Even and odd bytes separate the two lanes and the two enable codes. An even-address word shows that the job takes one cycle and that the byte order is correct. An odd-address word shows the split order, the second address and how the halves are rejoined.

A split word at the top address shows the wrap to zero. Byte reads after word writes show where each half of a word actually landed. The bus answers with both short and long ready delays, which shows the hold behaviour and checks that no progress is made without ready.

// File: rtl/lane_seq.sv
module lane_seq #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic          req_word,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          bus_strobe,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic          bus_bhe_n,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ready
);
  localparam int BW = DW / 2;
  typedef enum logic [1:0] {IDLE, FIRST, SECOND} st_t;

  st_t           st;
  logic          r_we, r_word;
  logic [AW-1:0] r_addr;
  logic [DW-1:0] r_wd;
  logic [BW-1:0] lo_byte;
  logic          split;
  logic          odd;

  assign odd        = r_addr[0];
  assign split      = r_word & odd;
  assign req_ready  = (st == IDLE);
  assign bus_strobe = (st != IDLE);
  assign bus_we     = r_we & bus_strobe;
  assign bus_addr   = (st == SECOND) ? r_addr + AW'(1) : r_addr;
  assign bus_bhe_n  = (st == SECOND) | (~r_word & ~odd);

  always_comb begin
    if (st == SECOND)     bus_wdata = {{BW{1'b0}}, r_wd[DW-1:BW]};
    else if (r_word & ~odd) bus_wdata = r_wd;
    else if (odd)         bus_wdata = {r_wd[BW-1:0], {BW{1'b0}}};
    else                  bus_wdata = {{BW{1'b0}}, r_wd[BW-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= IDLE;
      done    <= 1'b0;
      rdata   <= '0;
      r_we    <= 1'b0;
      r_word  <= 1'b0;
      r_addr  <= '0;
      r_wd    <= '0;
      lo_byte <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (req_valid) begin
          r_we   <= req_write;
          r_word <= req_word;
          r_addr <= req_addr;
          r_wd   <= req_wdata;
          st     <= FIRST;
        end
        FIRST: if (bus_ready) begin
          if (split) begin
            lo_byte <= bus_rdata[DW-1:BW];
            st      <= SECOND;
          end else begin
            done <= 1'b1;
            st   <= IDLE;
            if (!r_we) begin
              if (r_word)   rdata <= bus_rdata;
              else if (odd) rdata <= {{BW{1'b0}}, bus_rdata[DW-1:BW]};
              else          rdata <= {{BW{1'b0}}, bus_rdata[BW-1:0]};
            end
          end
        end
        SECOND: if (bus_ready) begin
          done <= 1'b1;
          st   <= IDLE;
          if (!r_we) rdata <= {bus_rdata[BW-1:0], lo_byte};
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module lane_seq_chk #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          done,
  input logic          bus_strobe,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic          bus_bhe_n,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_ready
);
  a_r9_no_dead_code: assert property (@(posedge clk) disable iff (!rst_n)
    bus_strobe |-> !(bus_bhe_n && bus_addr[0]));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && !bus_ready) |=> (bus_strobe && $stable({bus_we, bus_addr, bus_bhe_n, bus_wdata})));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  a_r1_idle_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !bus_strobe);

  a_r7_no_done_without_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && !bus_ready) |=> !done);
endmodule

bind lane_seq lane_seq_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/sim_lane_seq.sv
`timescale 1ns/1ps
module sim_lane_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic        req_word = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        done;
  logic [15:0] rdata;
  logic        bus_strobe, bus_we, bus_bhe_n;
  logic [19:0] bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata = '0;
  logic        bus_ready = 1'b0;

  always #2.5 clk = ~clk;

  lane_seq u0 (.*);

  typedef struct { logic [19:0] a; logic bhe_n; logic we; logic [15:0] wd; string tag; } cyc_t;
  typedef struct { logic rd; logic [15:0] d; string tag; } res_t;
  cyc_t cq[$];
  res_t rq[$];

  int checks = 0, failures = 0, lat = 1, cnt = 0, cycles = 0;
  logic [7:0] mem [int];
  logic [7:0] refm [int];

  function automatic logic [7:0] init_b(logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], 4'h5};
  endfunction
  function automatic logic [7:0] bus_b(logic [19:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : init_b(a);
  endfunction
  function automatic logic [7:0] ref_b(logic [19:0] a);
    return refm.exists(int'(a)) ? refm[int'(a)] : init_b(a);
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(negedge clk) begin
    if (bus_ready) begin
      bus_ready <= 1'b0;
      cnt <= 0;
    end else if (bus_strobe) begin
      if (cnt + 1 >= lat) begin
        cyc_t e;
        bus_ready <= 1'b1;
        bus_rdata <= {bus_b(bus_addr | 20'h1), bus_b(bus_addr & ~20'h1)};
        if (bus_we) begin
          if (!bus_addr[0]) mem[int'(bus_addr)] = bus_wdata[7:0];
          if (!bus_bhe_n)   mem[int'(bus_addr | 20'h1)] = bus_wdata[15:8];
        end
        if (cq.size() == 0) check(0, "unexpected bus cycle", {12'h0, bus_addr}, 0);
        else begin
          e = cq.pop_front();
          check(bus_addr == e.a && bus_bhe_n == e.bhe_n && bus_we == e.we &&
                (!e.we || bus_wdata == e.wd), e.tag,
                {bus_we, bus_bhe_n, bus_addr, bus_wdata[9:0]},
                {e.we, e.bhe_n, e.a, e.wd[9:0]});
        end
      end else cnt <= cnt + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (rq.size() == 0) check(0, "R7 unexpected done", 0, 1);
      else begin
        res_t r;
        r = rq.pop_front();
        check(req_ready == 1'b1, "R7 req_ready with done", req_ready, 1);
        if (r.rd) check(rdata == r.d, r.tag, rdata, r.d);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      check(0, "watchdog", cycles, 20000);
      report();
    end
  end

  task automatic push_cyc(logic [19:0] a, logic bhe_n, logic we, logic [15:0] wd, string tag);
    cyc_t c;
    c.a = a; c.bhe_n = bhe_n; c.we = we; c.wd = wd; c.tag = tag;
    cq.push_back(c);
  endtask

  task automatic req(logic we, logic word, logic [19:0] a, logic [15:0] wd, string tag);
    res_t r;
    logic [19:0] a1;
    a1 = a + 20'h1;
    r.rd = !we; r.tag = tag; r.d = '0;
    if (!word && !a[0]) begin
      push_cyc(a, 1'b1, we, {8'h00, wd[7:0]}, tag);
      if (we) refm[int'(a)] = wd[7:0]; else r.d = {8'h00, ref_b(a)};
    end else if (!word) begin
      push_cyc(a, 1'b0, we, {wd[7:0], 8'h00}, tag);
      if (we) refm[int'(a)] = wd[7:0]; else r.d = {8'h00, ref_b(a)};
    end else if (!a[0]) begin
      push_cyc(a, 1'b0, we, wd, tag);
      if (we) begin refm[int'(a)] = wd[7:0]; refm[int'(a1)] = wd[15:8]; end
      else r.d = {ref_b(a1), ref_b(a)};
    end else begin
      push_cyc(a, 1'b0, we, {wd[7:0], 8'h00}, tag);
      push_cyc(a1, 1'b1, we, {8'h00, wd[15:8]}, tag);
      if (we) begin refm[int'(a)] = wd[7:0]; refm[int'(a1)] = wd[15:8]; end
      else r.d = {ref_b(a1), ref_b(a)};
    end
    rq.push_back(r);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = we; req_word = word; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R7 busy after accept", req_ready, 0);
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    check(bus_strobe == 1'b0, "R1 strobe after reset", bus_strobe, 0);
    check(done == 1'b0, "R1 done after reset", done, 0);

    lat = 1;
    req(1, 0, 20'h00010, 16'h77A5, "R2 even byte write");
    req(1, 0, 20'h00013, 16'h665C, "R3 odd byte write");
    req(0, 0, 20'h00010, 16'h0, "R2 even byte read");
    req(0, 0, 20'h00013, 16'h0, "R3 odd byte read");
    req(0, 1, 20'h00012, 16'h0, "R4 aligned read around bytes");
    req(1, 1, 20'h00100, 16'hBEEF, "R4 aligned word write");
    req(0, 1, 20'h00100, 16'h0, "R4 aligned word read");
    req(0, 0, 20'h00101, 16'h0, "R4 high byte landed odd");
    lat = 3;
    req(1, 1, 20'h00201, 16'h1234, "R5 split word write");
    req(0, 1, 20'h00201, 16'h0, "R5 split word read");
    req(0, 0, 20'h00201, 16'h0, "R5 low byte at odd address");
    req(0, 0, 20'h00202, 16'h0, "R5 high byte at next address");
    req(0, 1, 20'h00401, 16'h0, "R5 split read of initial data");
    lat = 2;
    req(1, 1, 20'hFFFFF, 16'hCAFE, "R6 wrap split write");
    req(0, 1, 20'hFFFFF, 16'h0, "R6 wrap split read");
    req(0, 0, 20'h00000, 16'h0, "R6 high byte at zero");
    req(0, 0, 20'hFFFFF, 16'h0, "R6 low byte at top");
    lat = 1;
    req(0, 1, 20'h00200, 16'h0, "R4 aligned read of split data");

    repeat (4) @(negedge clk);
    check(cq.size() == 0, "R5 bus cycles all seen", cq.size(), 0);
    check(rq.size() == 0, "R7 all requests done", rq.size(), 0);
    check(bus_strobe == 1'b0, "R7 idle at end", bus_strobe, 0);
    report();
  end
endmodule